// File: doc/BRIEF.md
# Character LCD Parallel Write Controller

This block drives a character LCD module of the common parallel type through an 8-bit data bus and three control lines: register select, read/write and enable. After reset it waits for the panel to power up. It then plays a fixed command script that sets 8-bit two-line operation, switches the display off, clears it, sets the entry mode and switches the display on. The busy flag of the panel is never polled. Every delay is a parameterized count of clock cycles.

Once the script has finished, the block accepts single bytes from a valid/ready request port. Each byte is either an instruction (register select low) or a character code (register select high). For every byte the controller sets the bus and register select first, raises enable for a fixed width, and lowers it so that the panel latches the byte. It then holds the bus for a gap and waits out the command execution time before it accepts the next byte. The clear instruction gets a longer wait than other instructions.

Top module: `lcd_par_writer`

## Requirements
- R1: While rst_n is low, lcd_e, lcd_rw, req_ready and init_done are all 0.
- R2: The first rising edge of lcd_e comes no earlier than PWRUP_CYC and no later than PWRUP_CYC+6 clock cycles after rst_n is released.
- R3: After power-up the block writes exactly five instruction bytes with lcd_rs=0, in this order: 0x38, 0x08, 0x01, 0x06, 0x0C.
- R4: init_done rises only after the last script byte and its wait have completed, and then stays high until reset. req_ready is never high while init_done is low.
- R5: lcd_e stays high for exactly EHIGH_CYC cycles per pulse. lcd_db and lcd_rs are set at least one cycle before lcd_e rises, and are held unchanged while lcd_e is high and for the cycle after it falls.
- R6: A request with req_is_data=0 is written with lcd_rs=0, and one with req_is_data=1 with lcd_rs=1. req_byte bit 0 appears on lcd_db bit 0, so character 'A' is driven as 0x41.
- R7: lcd_rw is 0 at all times.
- R8: After a request is accepted, req_ready stays low for exactly 1+EHIGH_CYC+EGAP_CYC+CMD_WAIT_CYC cycles for any byte other than the clear instruction.
- R9: An instruction byte 0x01 (req_is_data=0) keeps req_ready low for 1+EHIGH_CYC+EGAP_CYC+CLR_WAIT_CYC cycles. A character byte 0x01 uses the normal wait.
- R10: A req_valid pulse given while req_ready is low is not taken: it causes no enable pulse and no bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A byte write is offered |
| req_is_data | input | 1 | 1 = character byte, 0 = instruction byte |
| req_byte | input | 8 | Byte to write |
| req_ready | output | 1 | The controller takes the offered byte this cycle |
| init_done | output | 1 | The power-up script has completed |
| lcd_rs | output | 1 | Register select to the panel |
| lcd_rw | output | 1 | Read/write line, always write |
| lcd_e | output | 1 | Enable strobe; the panel latches on its falling edge |
| lcd_db | output | 8 | Parallel data bus |

## Verification
A bus monitor records register select and the byte at every falling edge of enable. It measures each pulse width and checks that the bus is stable around the strobe. A design that moves the bus together with the rising edge, or frees it at the falling edge, breaks this check at once. The bench times the ready gap after each accepted byte. It compares the gap for an instruction clear with the gap for a character byte of the same value, which catches a clear detect that ignores register select or does not stretch the wait. It also pulses a request while the controller is busy, which exposes a design that drops its busy gating and sends an extra byte.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_EHIGH,
    SQ_HOLD,
    SQ_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    IN_PWRUP,
    IN_ISSUE,
    IN_DRAIN,
    IN_DONE
  } init_state_e;

  localparam int unsigned SCRIPT_LEN = 5;
  localparam logic [7:0]  CMD_CLEAR  = 8'h01;

  // Power-up script, issued in this order
  function automatic logic [7:0] init_cmd(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h38;  // 8-bit bus, two lines
      3'd1:    b = 8'h08;  // display off
      3'd2:    b = CMD_CLEAR;
      3'd3:    b = 8'h06;  // cursor increments, no shift
      default: b = 8'h0C;  // display on, no cursor
    endcase
    return b;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lcd_down_timer.sv
module lcd_down_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_byte_seq.sv
module lcd_byte_seq
  import lcd_wr_pkg::*;
#(
  parameter int unsigned EHIGH_CYC    = 24,
  parameter int unsigned EGAP_CYC     = 24,
  parameter int unsigned CMD_WAIT_CYC = 2000,
  parameter int unsigned CLR_WAIT_CYC = 80000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_is_data,
  input  logic [7:0] start_byte,
  output logic       idle,
  output logic       bus_rs,
  output logic       bus_e,
  output logic [7:0] bus_db
);

  localparam int unsigned MAXC = max_of4(EHIGH_CYC, EGAP_CYC, CMD_WAIT_CYC, CLR_WAIT_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_state_e    state_q, state_d;
  logic          rs_q;
  logic [7:0]    db_q;
  logic          e_q;
  logic          cap_en;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          is_clear;

  lcd_down_timer #(.W(CW), .RST_VAL(0)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign is_clear = !rs_q && (db_q == CMD_CLEAR);

  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      SQ_IDLE: if (start) begin
        cap_en  = 1'b1;
        state_d = SQ_SETUP;
      end
      SQ_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(EHIGH_CYC - 1);
        state_d  = SQ_EHIGH;
      end
      SQ_EHIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CW'(EGAP_CYC - 1);
        state_d  = SQ_HOLD;
      end
      SQ_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = is_clear ? CW'(CLR_WAIT_CYC - 1) : CW'(CMD_WAIT_CYC - 1);
        state_d  = SQ_WAIT;
      end
      SQ_WAIT: if (tmr_zero) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      e_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      e_q     <= (state_d == SQ_EHIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b0;
      db_q <= '0;
    end else if (cap_en) begin
      rs_q <= start_is_data;
      db_q <= start_byte;
    end
  end

  assign idle   = (state_q == SQ_IDLE);
  assign bus_rs = rs_q;
  assign bus_e  = e_q;
  assign bus_db = db_q;

endmodule

// File: rtl/lcd_init_ctl.sv
module lcd_init_ctl
  import lcd_wr_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 800000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_idle,
  output logic       issue,
  output logic [7:0] issue_byte,
  output logic       done
);

  localparam int unsigned PW = $clog2(PWRUP_CYC + 1);

  init_state_e state_q, state_d;
  logic [2:0]  idx_q;
  logic        idx_en;
  logic        pw_zero;

  lcd_down_timer #(.W(PW), .RST_VAL(PWRUP_CYC - 1)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ('0),
    .zero     (pw_zero)
  );

  always_comb begin
    state_d = state_q;
    issue   = 1'b0;
    idx_en  = 1'b0;
    case (state_q)
      IN_PWRUP: if (pw_zero) state_d = IN_ISSUE;
      IN_ISSUE: if (seq_idle) begin
        issue = 1'b1;
        if (idx_q == 3'(SCRIPT_LEN - 1)) state_d = IN_DRAIN;
        else                             idx_en  = 1'b1;
      end
      IN_DRAIN: if (seq_idle) state_d = IN_DONE;
      default:  state_d = IN_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= IN_PWRUP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_q + 1'b1;
  end

  assign issue_byte = init_cmd(idx_q);
  assign done       = (state_q == IN_DONE);

endmodule

// File: rtl/lcd_par_writer.sv
module lcd_par_writer #(
  parameter int unsigned PWRUP_CYC       = 800000,
  parameter int unsigned EHIGH_CYC       = 24,
  parameter int unsigned EGAP_CYC        = 24,
  parameter int unsigned CMD_WAIT_CYC    = 2000,
  parameter int unsigned CLR_WAIT_CYC    = 80000,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       req_ready,
  output logic       init_done,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);

  logic [RST_SYNC_STAGES-1:0] rst_pipe_q;
  logic                       rst_int_n;
  logic                       seq_idle;
  logic                       init_issue;
  logic [7:0]                 init_byte;
  logic                       seq_start;
  logic                       seq_is_data;
  logic [7:0]                 seq_byte;

  // Assert asynchronously, release after RST_SYNC_STAGES clock edges
  generate
    if (RST_SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= {rst_pipe_q[RST_SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_pipe_q[RST_SYNC_STAGES-1];

  lcd_init_ctl #(.PWRUP_CYC(PWRUP_CYC)) u_init (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .seq_idle   (seq_idle),
    .issue      (init_issue),
    .issue_byte (init_byte),
    .done       (init_done)
  );

  // Before the script finishes only the init controller reaches the sequencer
  always_comb begin
    if (init_done) begin
      seq_start   = req_valid & seq_idle;
      seq_is_data = req_is_data;
      seq_byte    = req_byte;
    end else begin
      seq_start   = init_issue;
      seq_is_data = 1'b0;
      seq_byte    = init_byte;
    end
  end

  lcd_byte_seq #(
    .EHIGH_CYC    (EHIGH_CYC),
    .EGAP_CYC     (EGAP_CYC),
    .CMD_WAIT_CYC (CMD_WAIT_CYC),
    .CLR_WAIT_CYC (CLR_WAIT_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start         (seq_start),
    .start_is_data (seq_is_data),
    .start_byte    (seq_byte),
    .idle          (seq_idle),
    .bus_rs        (lcd_rs),
    .bus_e         (lcd_e),
    .bus_db        (lcd_db)
  );

  assign req_ready = init_done & seq_idle;
  assign lcd_rw    = 1'b0;

endmodule

// File: rtl/lcd_par_writer_chk.sv
module lcd_par_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       init_done,
  input logic       lcd_rs,
  input logic       lcd_e,
  input logic [7:0] lcd_db
);

  // R5: bus already set in the cycle before the enable edge
  a_r5_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R5: bus frozen while enable is high
  a_r5_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R5: bus held through the fall and the cycle after it
  a_r5_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)) ##1 ($stable(lcd_db) && $stable(lcd_rs)));

  // R4: requests are never taken before the script ends
  a_r4_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);

  // R4: init_done never drops without reset
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R10: no request is accepted during a strobe
  a_r10_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready);

endmodule

bind lcd_par_writer lcd_par_writer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .init_done (init_done),
  .lcd_rs    (lcd_rs),
  .lcd_e     (lcd_e),
  .lcd_db    (lcd_db)
);

// File: tb/lcd_par_writer_tb_top.sv
module lcd_par_writer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PWRUP      = 50;
  localparam int EH         = 4;
  localparam int EL         = 3;
  localparam int CMDW       = 6;
  localparam int CLRW       = 25;
  localparam int WD_CYCLES  = 20000;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_is_data;
  logic [7:0] req_byte;
  logic       req_ready;
  logic       init_done;
  logic       lcd_rs;
  logic       lcd_rw;
  logic       lcd_e;
  logic [7:0] lcd_db;

  lcd_par_writer #(
    .PWRUP_CYC    (PWRUP),
    .EHIGH_CYC    (EH),
    .EGAP_CYC     (EL),
    .CMD_WAIT_CYC (CMDW),
    .CLR_WAIT_CYC (CLRW)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_data (req_is_data),
    .req_byte    (req_byte),
    .req_ready   (req_ready),
    .init_done   (init_done),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_e       (lcd_e),
    .lcd_db      (lcd_db)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bus monitor: captures {rs, byte} at each falling edge of enable
  int         mon_checks = 0;
  int         mon_fails  = 0;
  int         cyc;
  int         first_rise;
  int         hi_cnt;
  bit         post_fall;
  logic       e_prev, rs_prev, done_prev;
  logic [7:0] db_prev;
  logic       cap_rs [0:63];
  logic [7:0] cap_db [0:63];
  int         cap_n;

  function automatic void mon_check(input bit ok, input string req, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc        = 0;
      first_rise = -1;
      hi_cnt     = 0;
      post_fall  = 0;
      cap_n      = 0;
    end else begin
      cyc++;
      mon_check(lcd_rw === 1'b0, "R7 rw low", int'(lcd_rw), 0);
      if (lcd_e && !e_prev) begin
        if (first_rise < 0) first_rise = cyc;
        mon_check({lcd_rs, lcd_db} == {rs_prev, db_prev}, "R5 setup before rise",
                  int'({lcd_rs, lcd_db}), int'({rs_prev, db_prev}));
        hi_cnt = 1;
      end else if (lcd_e && e_prev) begin
        hi_cnt++;
        mon_check({lcd_rs, lcd_db} == {rs_prev, db_prev}, "R5 stable while high",
                  int'({lcd_rs, lcd_db}), int'({rs_prev, db_prev}));
      end else if (!lcd_e && e_prev) begin
        mon_check({lcd_rs, lcd_db} == {rs_prev, db_prev}, "R5 stable at fall",
                  int'({lcd_rs, lcd_db}), int'({rs_prev, db_prev}));
        mon_check(hi_cnt == EH, "R5 enable width", hi_cnt, EH);
        if (cap_n < 64) begin
          cap_rs[cap_n] = rs_prev;
          cap_db[cap_n] = db_prev;
        end
        cap_n++;
        post_fall = 1;
      end else if (post_fall) begin
        mon_check({lcd_rs, lcd_db} == {rs_prev, db_prev}, "R5 hold after fall",
                  int'({lcd_rs, lcd_db}), int'({rs_prev, db_prev}));
        post_fall = 0;
      end
      if (req_ready && !init_done) mon_check(1'b0, "R4 ready before init", 1, 0);
      if (done_prev && !init_done) mon_check(1'b0, "R4 init_done dropped", 0, 1);
    end
    e_prev    = lcd_e;
    rs_prev   = lcd_rs;
    db_prev   = lcd_db;
    done_prev = init_done;
  end

  // Sends one byte and returns the number of cycles req_ready stayed low
  task automatic send(input bit is_data, input logic [7:0] b, output int busy);
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    req_is_data = is_data;
    req_byte    = b;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready && busy < 1000) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(lcd_e === 1'b0, "R1 reset lcd_e", int'(lcd_e), 0);
    check(lcd_rw === 1'b0, "R1 reset lcd_rw", int'(lcd_rw), 0);
    check(req_ready === 1'b0, "R1 reset req_ready", int'(req_ready), 0);
    check(init_done === 1'b0, "R1 reset init_done", int'(init_done), 0);
  endtask

  task automatic t_init();
    logic [7:0] exp_b [0:4];
    int waited;
    exp_b[0] = 8'h38; exp_b[1] = 8'h08; exp_b[2] = 8'h01; exp_b[3] = 8'h06; exp_b[4] = 8'h0C;
    waited = 0;
    while (!init_done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(init_done === 1'b1, "R4 init completes", int'(init_done), 1);
    check(first_rise >= PWRUP && first_rise <= PWRUP + 6, "R2 power-up wait", first_rise, PWRUP);
    check(cap_n == 5, "R3 script length", cap_n, 5);
    for (int i = 0; i < 5; i++) begin
      check(cap_db[i] == exp_b[i], "R3 script byte", int'(cap_db[i]), int'(exp_b[i]));
      check(cap_rs[i] == 1'b0, "R3 script rs", int'(cap_rs[i]), 0);
    end
    // last byte is followed by the normal wait before done: ready immediately
    check(req_ready === 1'b1, "R4 ready after init", int'(req_ready), 1);
  endtask

  task automatic t_char_and_instr();
    int busy, n0;
    n0 = cap_n;
    send(1'b1, 8'h41, busy);
    check(cap_n == n0 + 1, "R6 char written", cap_n, n0 + 1);
    check(cap_rs[n0] == 1'b1, "R6 char rs high", int'(cap_rs[n0]), 1);
    check(cap_db[n0] == 8'h41, "R6 char 'A' code", int'(cap_db[n0]), 'h41);
    check(busy == 1 + EH + EL + CMDW, "R8 char busy", busy, 1 + EH + EL + CMDW);
    send(1'b0, 8'hC0, busy);
    check(cap_rs[n0+1] == 1'b0, "R6 instr rs low", int'(cap_rs[n0+1]), 0);
    check(cap_db[n0+1] == 8'hC0, "R6 instr byte", int'(cap_db[n0+1]), 'hC0);
    check(busy == 1 + EH + EL + CMDW, "R8 instr busy", busy, 1 + EH + EL + CMDW);
  endtask

  task automatic t_stream();
    logic [7:0] msg [0:4];
    int busy, n0;
    msg[0] = 8'h48; msg[1] = 8'h65; msg[2] = 8'h6C; msg[3] = 8'h80; msg[4] = 8'h21;
    n0 = cap_n;
    for (int i = 0; i < 5; i++) send(i != 3, msg[i], busy);
    for (int i = 0; i < 5; i++) begin
      check(cap_db[n0+i] == msg[i], "R6 stream byte", int'(cap_db[n0+i]), int'(msg[i]));
      check(cap_rs[n0+i] == (i != 3), "R6 stream rs", int'(cap_rs[n0+i]), int'(i != 3));
    end
  endtask

  task automatic t_clear();
    int busy, n0;
    n0 = cap_n;
    send(1'b0, 8'h01, busy);
    check(busy == 1 + EH + EL + CLRW, "R9 clear long wait", busy, 1 + EH + EL + CLRW);
    check(cap_rs[n0] == 1'b0 && cap_db[n0] == 8'h01, "R9 clear byte",
          int'({cap_rs[n0], cap_db[n0]}), 'h001);
    send(1'b1, 8'h01, busy);
    check(busy == 1 + EH + EL + CMDW, "R9 char 0x01 normal wait", busy, 1 + EH + EL + CMDW);
  endtask

  task automatic t_busy_ignore();
    int n0, waited;
    n0 = cap_n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b0; req_byte = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!req_ready && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    repeat (20) @(negedge clk);
    check(cap_n == n0 + 1, "R10 busy request ignored", cap_n, n0 + 1);
    check(cap_db[n0] == 8'h5A, "R10 accepted byte", int'(cap_db[n0]), 'h5A);
    check(lcd_db == 8'h5A, "R10 bus unchanged", int'(lcd_db), 'h5A);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks + mon_checks, n_fails + mon_fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_is_data = 1'b0;
    req_byte    = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_init();
    t_char_and_instr();
    t_stream();
    t_clear();
    t_busy_ignore();
    check(mon_fails == 0, "R5 R7 monitor clean", mon_fails, 0);
    summary();
    $finish;
  end

endmodule